// File: doc/BRIEF.md
# Phase-Alignable Integer Clock Divider

This block divides an input sample clock by a programmable integer from 1 to 8. A single configuration word sets the division ratio, a flag that asks for duty-cycle stabilization, and two bits that control how an external alignment strobe is handled. Several copies fed by the same clock and the same strobe end up dividing in phase, because every accepted strobe puts the divider back into its reset phase.

The strobe input goes through a two-stage synchronizer in the input clock domain. Only its rising edge counts. In continuous mode every accepted edge realigns the divider. In one-shot mode only the first edge after a configuration write is accepted, and a status output reports when that one edge has been used. The stabilizer-request output is forced on whenever the divider is actually dividing, and otherwise follows the programmed flag.

A new ratio takes effect at the end of the current output period, or at once on an accepted strobe, so the output never shows a truncated pulse.

Top module: `pdiv_aligned`

## Requirements
- R1: After reset the active ratio is 1 (`div_clk` follows `clk_in`), `stab_en` is 0 and `sync_spent` is 0.
- R2: For an active ratio N from 2 to 8, `div_clk` is periodic with N input cycles and is high for the first floor(N/2) input cycles of each period.
- R3: The ratio field is `cfg_wdata[7:4]`. A value of 1 or 0 gives ratio 1, where `div_clk` equals `clk_in`. Values above 8 are treated as 8.
- R4: `stab_en` equals `cfg_wdata[0]` as last written, OR'd with (active ratio is not 1).
- R5: A newly written ratio becomes active only at the end of the current output period (or on an accepted strobe), and the new period starts high.
- R6: An accepted rising edge of `sync_in` (stable from one clock edge to the next) restarts the period. The counter returns to its first cycle, and the output is high from the third `clk_in` rising edge after `sync_in` rises.
- R7: A `sync_in` pulse held high for many cycles counts as one strobe.
- R8: With `cfg_wdata[1]` = 0 last written, `sync_in` has no effect on `div_clk` or `sync_spent`.
- R9: With `cfg_wdata[1]` = 1 and `cfg_wdata[2]` = 1 (one-shot), only the first strobe after a write is accepted. `sync_spent` then goes to 1, and a later write clears it and re-arms the strobe.
- R10: With `cfg_wdata[1]` = 1 and `cfg_wdata[2]` = 0 (continuous), every strobe is accepted and `sync_spent` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Asynchronous alignment strobe |
| cfg_we | input | 1 | Configuration write enable, one cycle per write |
| cfg_wdata | input | 8 | Configuration word: [0] stabilizer request, [1] strobe enable, [2] one-shot, [7:4] ratio |
| div_clk | output | 1 | Divided clock |
| stab_en | output | 1 | Duty-cycle stabilizer enable request |
| sync_spent | output | 1 | One-shot strobe has been used since the last write |

## Verification
A wrong counter or phase state shows up directly on `div_clk`. The fault is visible within one output period (at most eight input cycles) as a high or low level sampled in the wrong cycle. A wrong arming state shows up differently. An extra or missing realignment moves the output phase three cycles after the strobe, and `sync_spent` shows a wrong value on the next cycle. A ratio taken at the wrong moment changes the length of the period in which the write occurred. The bench compares every half cycle against a cycle-level model, so each of these shows up in the cycle where it first appears.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
   // configuration word field positions
   localparam int STAB_BIT   = 0;
   localparam int SEN_BIT    = 1;
   localparam int ONESHOT_BIT = 2;
   localparam int RATIO_LSB  = 4;

   typedef struct packed {
      logic stab_req;
      logic sync_en;
      logic oneshot;
   } pdiv_ctl_t;
endpackage

// File: rtl/pdiv_cfg.sv
module pdiv_cfg
   import pdiv_pkg::*;
#(
   parameter int RATIO_W   = 4,
   parameter int MAX_RATIO = 8,
   localparam int CFG_W    = RATIO_LSB + RATIO_W
)(
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [CFG_W-1:0]   cfg_wdata,
   output pdiv_ctl_t          ctl,
   output logic [RATIO_W-1:0] pend_ratio
);
   localparam logic [RATIO_W-1:0] MAXV = RATIO_W'(MAX_RATIO);

   logic [RATIO_W-1:0] code_q;
   pdiv_ctl_t          ctl_q;

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= '0;
         ctl_q  <= '0;
      end else if (cfg_we) begin
         code_q         <= cfg_wdata[RATIO_LSB +: RATIO_W];
         ctl_q.stab_req <= cfg_wdata[STAB_BIT];
         ctl_q.sync_en  <= cfg_wdata[SEN_BIT];
         ctl_q.oneshot  <= cfg_wdata[ONESHOT_BIT];
      end
   end

   // zero means divide-by-one, anything past the limit saturates
   always_comb begin
      if (code_q == '0)      pend_ratio = RATIO_W'(1);
      else if (code_q > MAXV) pend_ratio = MAXV;
      else                   pend_ratio = code_q;
   end

   assign ctl = ctl_q;

   a_r3_pend_range: assert property (@(posedge clk_in) disable iff (!rst_n)
      (pend_ratio >= RATIO_W'(1)) && (pend_ratio <= MAXV));
endmodule

// File: rtl/pdiv_sync.sv
module pdiv_sync
   import pdiv_pkg::*;
#(
   parameter int STAGES = 2
)(
   input  logic      clk_in,
   input  logic      rst_n,
   input  logic      sync_in,
   input  logic      cfg_we,
   input  pdiv_ctl_t ctl,
   output logic      sync_evt,
   output logic      spent
);
   logic [STAGES-1:0] chain;
   logic              last_q;
   logic              armed_q;
   logic              spent_q;
   logic              rise;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pdiv_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk_in or negedge rst_n) begin
               if (!rst_n) chain[0] <= 1'b0;
               else        chain[0] <= sync_in;
            end
         end else begin : g_next
            always_ff @(posedge clk_in or negedge rst_n) begin
               if (!rst_n) chain[i] <= 1'b0;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain[STAGES-1];
   end

   assign rise     = chain[STAGES-1] & ~last_q;
   assign sync_evt = rise & ctl.sync_en & (~ctl.oneshot | armed_q);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
         spent_q <= 1'b0;
      end else if (cfg_we) begin
         armed_q <= 1'b1;
         spent_q <= 1'b0;
      end else if (sync_evt && ctl.oneshot) begin
         armed_q <= 1'b0;
         spent_q <= 1'b1;
      end
   end

   assign spent = spent_q;

   a_r8_disabled_quiet: assert property (@(posedge clk_in) disable iff (!rst_n)
      !ctl.sync_en |-> !sync_evt);
   a_r9_no_second_take: assert property (@(posedge clk_in) disable iff (!rst_n)
      (ctl.oneshot && spent_q) |-> !sync_evt);
   a_r9_spent_marks: assert property (@(posedge clk_in) disable iff (!rst_n)
      (sync_evt && ctl.oneshot && !cfg_we) |=> spent_q);
   a_r7_single_event: assert property (@(posedge clk_in) disable iff (!rst_n)
      sync_evt |=> !sync_evt);
   a_r10_never_spent: assert property (@(posedge clk_in) disable iff (!rst_n)
      (!ctl.oneshot && !cfg_we && !spent_q) |=> !spent_q);
endmodule

// File: rtl/pdiv_core.sv
module pdiv_core #(
   parameter int RATIO_W     = 4,
   parameter int MAX_RATIO   = 8,
   parameter int RESET_RATIO = 1
)(
   input  logic               clk_in,
   input  logic               rst_n,
   input  logic               sync_evt,
   input  logic [RATIO_W-1:0] pend_ratio,
   output logic [RATIO_W-1:0] active_ratio,
   output logic               phase_hi
);
   logic [RATIO_W-1:0] cnt_q;
   logic [RATIO_W-1:0] act_q;
   logic               hi_q;
   logic [RATIO_W-1:0] nxt_cnt;
   logic               term;

   generate
      if (MAX_RATIO < 2 || MAX_RATIO >= (1 << RATIO_W)) begin : g_bad_max
         $error("pdiv_core: MAX_RATIO out of range for RATIO_W");
      end
      if (RESET_RATIO < 1 || RESET_RATIO > MAX_RATIO) begin : g_bad_rst
         $error("pdiv_core: RESET_RATIO out of range");
      end
   endgenerate

   assign nxt_cnt = cnt_q + 1'b1;
   assign term    = (cnt_q == act_q - 1'b1);

   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= RATIO_W'(RESET_RATIO);
         hi_q  <= (RESET_RATIO > 1);
      end else if (sync_evt || term) begin
         cnt_q <= '0;
         act_q <= pend_ratio;
         hi_q  <= ((pend_ratio >> 1) != '0);
      end else begin
         cnt_q <= nxt_cnt;
         hi_q  <= (nxt_cnt < (act_q >> 1));
      end
   end

   assign active_ratio = act_q;
   assign phase_hi     = hi_q;

   a_r2_cnt_in_period: assert property (@(posedge clk_in) disable iff (!rst_n)
      cnt_q < act_q);
   a_r5_ratio_hold: assert property (@(posedge clk_in) disable iff (!rst_n)
      !(sync_evt || term) |=> $stable(act_q));
   a_r6_sync_restart: assert property (@(posedge clk_in) disable iff (!rst_n)
      sync_evt |=> (cnt_q == '0));
   a_r2_period_starts_high: assert property (@(posedge clk_in) disable iff (!rst_n)
      ((cnt_q == '0) && (act_q > RATIO_W'(1))) |-> hi_q);
endmodule

// File: rtl/pdiv_aligned.sv
module pdiv_aligned
   import pdiv_pkg::*;
#(
   parameter int RATIO_W     = 4,
   parameter int MAX_RATIO   = 8,
   parameter int RESET_RATIO = 1,
   parameter int SYNC_STAGES = 2,
   localparam int CFG_W      = RATIO_LSB + RATIO_W
)(
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic             sync_in,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic             div_clk,
   output logic             stab_en,
   output logic             sync_spent
);
   pdiv_ctl_t          ctl;
   logic [RATIO_W-1:0] pend_ratio;
   logic [RATIO_W-1:0] active_ratio;
   logic               phase_hi;
   logic               sync_evt;
   logic               bypass;

   pdiv_cfg #(.RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO)) u_cfg (
      .clk_in(clk_in), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .ctl(ctl), .pend_ratio(pend_ratio));

   pdiv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_in(clk_in), .rst_n(rst_n), .sync_in(sync_in), .cfg_we(cfg_we),
      .ctl(ctl), .sync_evt(sync_evt), .spent(sync_spent));

   pdiv_core #(.RATIO_W(RATIO_W), .MAX_RATIO(MAX_RATIO), .RESET_RATIO(RESET_RATIO)) u_core (
      .clk_in(clk_in), .rst_n(rst_n), .sync_evt(sync_evt), .pend_ratio(pend_ratio),
      .active_ratio(active_ratio), .phase_hi(phase_hi));

   assign bypass  = (active_ratio == RATIO_W'(1));
   assign div_clk = bypass ? clk_in : phase_hi;
   assign stab_en = ctl.stab_req | ~bypass;

   a_r4_stab_forced: assert property (@(posedge clk_in) disable iff (!rst_n)
      (active_ratio != RATIO_W'(1)) |-> stab_en);
   a_r4_stab_follows_req: assert property (@(posedge clk_in) disable iff (!rst_n)
      (active_ratio == RATIO_W'(1)) |-> (stab_en == ctl.stab_req));
endmodule

// File: tb/pdiv_aligned_bench.sv
module pdiv_aligned_bench;
   timeunit 1ns; timeprecision 1ps;

   logic       clk_in = 1'b0;
   logic       rst_n = 1'b0;
   logic       sync_in = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       div_clk, stab_en, sync_spent;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   string cur_tag = "R1";

   typedef struct packed { logic byp; logic hi; logic stab; logic used; } exp_t;
   exp_t  exp_q[$];
   string tag_q[$];

   pdiv_aligned u_pdiv_aligned (
      .clk_in(clk_in), .rst_n(rst_n), .sync_in(sync_in), .cfg_we(cfg_we),
      .cfg_wdata(cfg_wdata), .div_clk(div_clk), .stab_en(stab_en),
      .sync_spent(sync_spent));

   always #5 clk_in = ~clk_in;

   // cycle-level reference model of the requirements
   logic m_s1, m_s2, m_s3;
   logic m_stab, m_en, m_one, m_armed, m_used;
   int   m_code, m_act, m_ph;
   logic m_hi;

   function automatic int eff_ratio(int code);
      if (code == 0) return 1;
      if (code > 8) return 8;
      return code;
   endfunction

   always @(posedge clk_in) begin
      logic take;
      int   pend;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0;
         m_stab = 0; m_en = 0; m_one = 0; m_armed = 1; m_used = 0;
         m_code = 0; m_act = 1; m_ph = 0; m_hi = 0;
      end else begin
         pend = eff_ratio(m_code);
         take = m_s2 && !m_s3 && m_en && (!m_one || m_armed);
         if (take || m_ph == m_act - 1) begin
            m_ph = 0; m_act = pend; m_hi = (pend / 2) > 0;
         end else begin
            m_ph = m_ph + 1; m_hi = m_ph < (m_act / 2);
         end
         if (cfg_we) begin
            m_armed = 1; m_used = 0;
         end else if (take && m_one) begin
            m_armed = 0; m_used = 1;
         end
         if (cfg_we) begin
            m_stab = cfg_wdata[0]; m_en = cfg_wdata[1];
            m_one = cfg_wdata[2]; m_code = cfg_wdata[7:4];
         end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      end
      exp_q.push_back('{byp: (m_act == 1), hi: m_hi,
                        stab: m_stab | (m_act != 1), used: m_used});
      tag_q.push_back(cur_tag);
   end

   task automatic chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // monitor: pop one expected item per cycle, check both clock phases
   always begin
      exp_t  e;
      string t;
      @(posedge clk_in);
      #2;
      if (exp_q.size() > 0) begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, "div_clk(high phase)", div_clk, e.byp ? 1'b1 : e.hi);
         chk(t, "stab_en", stab_en, e.stab);
         chk(t, "sync_spent", sync_spent, e.used);
         #5;
         chk(t, "div_clk(low phase)", div_clk, e.byp ? 1'b0 : e.hi);
      end
   end

   task automatic wr(bit stab, bit en, bit one, int code);
      @(negedge clk_in); #1;
      cfg_we = 1'b1;
      cfg_wdata = {code[3:0], 1'b0, one, en, stab};
      @(negedge clk_in); #1;
      cfg_we = 1'b0;
   endtask

   task automatic strobe(int len);
      @(negedge clk_in); #1;
      sync_in = 1'b1;
      repeat (len) @(negedge clk_in);
      #1;
      sync_in = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk_in);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 10);
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      cur_tag = "R1";
      idle(4);
      @(negedge clk_in); #1; rst_n = 1'b1;
      idle(3);
      cur_tag = "R2"; wr(0, 0, 0, 2); idle(12);
      wr(0, 0, 0, 3); idle(12);
      wr(0, 0, 0, 5); idle(15);
      wr(0, 0, 0, 8); idle(20);
      cur_tag = "R5"; idle(3); wr(0, 0, 0, 4); idle(2); wr(0, 0, 0, 7); idle(20);
      cur_tag = "R3"; wr(0, 0, 0, 0); idle(10);
      wr(0, 0, 0, 12); idle(20);
      wr(0, 0, 0, 1); idle(10);
      cur_tag = "R4"; wr(1, 0, 0, 1); idle(4); wr(0, 0, 0, 1); idle(4); wr(1, 0, 0, 3); idle(8);
      cur_tag = "R8"; wr(0, 0, 0, 6); idle(4); strobe(1); idle(14); strobe(3); idle(10);
      cur_tag = "R10"; wr(0, 1, 0, 6); idle(3); strobe(1); idle(7); strobe(1); idle(10);
      cur_tag = "R6"; wr(0, 1, 0, 5); idle(12); strobe(2); idle(12);
      cur_tag = "R7"; strobe(9); idle(12);
      cur_tag = "R9"; wr(0, 1, 1, 5); idle(3); strobe(1); idle(8);
      strobe(1); idle(9); strobe(1); idle(8);
      wr(0, 1, 1, 5); idle(4); strobe(1); idle(10);
      idle(2);
      finish_run();
   end
endmodule